// File: doc/BRIEF.md
# Oscillation Stabilization Wait Controller

This block keeps the core in reset, with its clock gated off, after a power-on reset. It also keeps the core clock gated after a stop request, until a fixed settling time of the oscillator has passed. Dedicated settling hardware is not needed. The block takes over two ordinary 8-bit down-counting timers (a low stage and a high stage) and chains them in hardware. It forces their preset values and counts a fixed number of prescaled oscillator ticks. The high stage overflowing marks the end of the wait.

After an external reset the low stage always counts the oscillator divided by 16. After a stop, the low stage counts whatever source its two select bits named when the stop was accepted. The wait is therefore the full settling time only if those bits were both zero. After a stop, the controller holds its counters frozen at their presets until a wake-up event arrives. Only then does it begin the exit wait. Stop requests that arrive during a wait are ignored. The block drives the core reset release, the core clock enable, the forced cascade control and the preset values towards the timer bank.

Top module: `osw_ctrl`

## Requirements
- R1: While `ext_rst_n` is low: `core_rst_n` = 0, `core_clk_en` = 0, `cascade_force` = 1, `lo_preset` = 0xFF and `hi_preset` = 0x07, whatever the other inputs.
- R2: After `ext_rst_n` rises, `core_rst_n` and `core_clk_en` both rise on the 32768th rising clock edge (16 × 256 × 8), counting the first edge with reset high as edge 1. `lo_src_sel` has no effect on this wait.
- R3: `cascade_force` is 1 exactly when `core_clk_en` is 0. The preset outputs read 0xFF and 0x07 while the cascade is forced, and 0x00 otherwise. Each forcing loads both stages with their presets.
- R4: A `stop_req` sampled high while running drops `core_clk_en` and raises `cascade_force` at that same edge. `core_rst_n` stays 1.
- R5: Once stopped and without `wake_evt`, `core_clk_en` stays 0 indefinitely and both stage counters hold their presets.
- R6: A `wake_evt` sampled high at edge W while stopped raises `core_clk_en` at edge W + 2048·D. D is set by `lo_src_sel` as captured at stop acceptance: 00 → 16, 01 → 2, 10 or 11 → 1.
- R7: `stop_req` during the reset wait or the stop-exit wait is ignored, and the release edge is unchanged.
- R8: `wake_evt` while running or during the reset wait has no effect: the clock stays enabled, or the release edge is unchanged, respectively.
- R9: Changes of `lo_src_sel` after stop acceptance do not alter the stop-exit wait length.
- R10: `core_clk_en` rises only in the cycle after the high stage overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| stop_req | input | 1 | One-cycle stop request strobe |
| wake_evt | input | 1 | Wake-up event that starts the stop-exit wait |
| lo_src_sel | input | 2 | Low-stage count source select (00 = /16, 01 = /2, 1x = /1) |
| core_rst_n | output | 1 | Internal reset release, active low |
| core_clk_en | output | 1 | Internal clock enable |
| cascade_force | output | 1 | Forces the high stage to count low-stage overflows |
| lo_preset | output | 8 | Forced preset for the low stage |
| hi_preset | output | 8 | Forced preset for the high stage |

## Verification
The assertions check several properties on every cycle:
- the clock enable and the forced cascade stay mutually exclusive;
- once released, the core reset stays released;
- a stop drops the clock in the same edge;
- the stage counters stay frozen while the controller waits for a wake-up;
- every clock release follows a high-stage overflow.

Only the directed scenarios can show that each release falls on the exact expected edge for each source setting. The same holds for showing that the reset wait ignores the select bits, that disturbing stop, wake and select activity mid-wait does not move the release, and that the select bits are captured at the moment of stop.

// File: rtl/osw_pkg.sv
package osw_pkg;

   typedef enum logic [1:0] {
      ST_RST_WAIT  = 2'd0,
      ST_RUN       = 2'd1,
      ST_STOPPED   = 2'd2,
      ST_STOP_WAIT = 2'd3
   } osw_state_e;

   typedef enum logic [1:0] {
      SRC_SLOW = 2'd0,
      SRC_MID  = 2'd1,
      SRC_FAST = 2'd2
   } osw_src_e;

   function automatic osw_src_e decode_src(input logic [1:0] sel);
      case (sel)
         2'b00:   decode_src = SRC_SLOW;
         2'b01:   decode_src = SRC_MID;
         default: decode_src = SRC_FAST;
      endcase
   endfunction

endpackage

// File: rtl/osw_prescaler.sv
module osw_prescaler #(
   parameter int DIV_SLOW = 16,
   parameter int DIV_MID  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  osw_pkg::osw_src_e  src,
   output logic               tick
);
   import osw_pkg::*;

   localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
   localparam logic [PW-1:0] M_SLOW = PW'(DIV_SLOW - 1);
   localparam logic [PW-1:0] M_MID  = PW'(DIV_MID - 1);

   generate
      if (DIV_SLOW < 1 || (DIV_SLOW & (DIV_SLOW - 1)) != 0) begin : g_bad_slow
         $error("osw_prescaler: DIV_SLOW must be a power of two");
      end
      if (DIV_MID < 1 || (DIV_MID & (DIV_MID - 1)) != 0 || DIV_MID > DIV_SLOW) begin : g_bad_mid
         $error("osw_prescaler: DIV_MID must be a power of two not above DIV_SLOW");
      end
   endgenerate

   logic [PW-1:0] cnt;
   logic          hit_slow;
   logic          hit_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   generate
      if (DIV_SLOW == 1) begin : g_slow_every
         assign hit_slow = 1'b1;
      end else begin : g_slow_tap
         assign hit_slow = ((cnt & M_SLOW) == M_SLOW);
      end
      if (DIV_MID == 1) begin : g_mid_every
         assign hit_mid = 1'b1;
      end else begin : g_mid_tap
         assign hit_mid = ((cnt & M_MID) == M_MID);
      end
   endgenerate

   always_comb begin
      case (src)
         SRC_SLOW: tick = run & hit_slow;
         SRC_MID:  tick = run & hit_mid;
         default:  tick = run;
      endcase
   end

endmodule

// File: rtl/osw_wait_timer.sv
module osw_wait_timer #(
   parameter int              TW     = 8,
   parameter logic [TW-1:0]   PRESET = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          tick,
   output logic [TW-1:0] cnt,
   output logic          ovf
);

   generate
      if (TW < 2) begin : g_bad_width
         $error("osw_wait_timer: TW must be at least 2");
      end
   endgenerate

   assign ovf = tick && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= PRESET;
      else if (load)    cnt <= PRESET;
      else if (ovf)     cnt <= PRESET;
      else if (tick)    cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/osw_seq.sv
module osw_seq (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop_req,
   input  logic               wake_evt,
   input  logic [1:0]         lo_src_sel,
   input  logic               wait_done,
   output osw_pkg::osw_state_e state,
   output logic               counting,
   output logic               load,
   output osw_pkg::osw_src_e  src
);
   import osw_pkg::*;

   osw_state_e state_q;
   osw_state_e state_d;
   osw_src_e   src_q;
   logic       stop_take;

   assign stop_take = (state_q == ST_RUN) && stop_req;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_RST_WAIT:  if (wait_done) state_d = ST_RUN;
         ST_RUN:       if (stop_req)  state_d = ST_STOPPED;
         ST_STOPPED:   if (wake_evt)  state_d = ST_STOP_WAIT;
         ST_STOP_WAIT: if (wait_done) state_d = ST_RUN;
         default:                     state_d = ST_RST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RST_WAIT;
         src_q   <= SRC_SLOW;
      end else begin
         state_q <= state_d;
         if (stop_take) src_q <= decode_src(lo_src_sel);
      end
   end

   assign state    = state_q;
   assign counting = (state_q == ST_RST_WAIT) || (state_q == ST_STOP_WAIT);
   assign load     = stop_take || (state_q == ST_STOPPED);
   assign src      = (state_q == ST_STOP_WAIT) ? src_q : SRC_SLOW;

endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl #(
   parameter int            TW        = 8,
   parameter logic [TW-1:0] LO_PRESET = 8'hFF,
   parameter logic [TW-1:0] HI_PRESET = 8'h07,
   parameter int            DIV_SLOW  = 16,
   parameter int            DIV_MID   = 2
) (
   input  logic          clk,
   input  logic          ext_rst_n,
   input  logic          stop_req,
   input  logic          wake_evt,
   input  logic [1:0]    lo_src_sel,
   output logic          core_rst_n,
   output logic          core_clk_en,
   output logic          cascade_force,
   output logic [TW-1:0] lo_preset,
   output logic [TW-1:0] hi_preset
);
   import osw_pkg::*;

   localparam int NSTAGE = 2;

   osw_state_e                 seq_state;
   logic                       seq_counting;
   logic                       seq_load;
   osw_src_e                   seq_src;
   logic                       seq_stopped;
   logic                       pre_tick;
   logic [NSTAGE-1:0]          stage_tick;
   logic [NSTAGE-1:0]          stage_ovf;
   logic [NSTAGE-1:0][TW-1:0]  stage_cnt;

   osw_seq u_seq (
      .clk        (clk),
      .rst_n      (ext_rst_n),
      .stop_req   (stop_req),
      .wake_evt   (wake_evt),
      .lo_src_sel (lo_src_sel),
      .wait_done  (stage_ovf[NSTAGE-1]),
      .state      (seq_state),
      .counting   (seq_counting),
      .load       (seq_load),
      .src        (seq_src)
   );

   osw_prescaler #(
      .DIV_SLOW (DIV_SLOW),
      .DIV_MID  (DIV_MID)
   ) u_pre (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .run   (seq_counting),
      .src   (seq_src),
      .tick  (pre_tick)
   );

   generate
      for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
         localparam logic [TW-1:0] P = (i == 0) ? LO_PRESET : HI_PRESET;
         if (i == 0) begin : g_first
            assign stage_tick[i] = pre_tick;
         end else begin : g_chain
            assign stage_tick[i] = stage_ovf[i-1];
         end
         osw_wait_timer #(
            .TW     (TW),
            .PRESET (P)
         ) u_tmr (
            .clk   (clk),
            .rst_n (ext_rst_n),
            .load  (seq_load),
            .tick  (stage_tick[i]),
            .cnt   (stage_cnt[i]),
            .ovf   (stage_ovf[i])
         );
      end
   endgenerate

   assign seq_stopped   = (seq_state == ST_STOPPED);
   assign core_rst_n    = (seq_state != ST_RST_WAIT);
   assign core_clk_en   = (seq_state == ST_RUN);
   assign cascade_force = ~core_clk_en;
   assign lo_preset     = cascade_force ? LO_PRESET : '0;
   assign hi_preset     = cascade_force ? HI_PRESET : '0;

endmodule

// File: rtl/osw_ctrl_chk.sv
module osw_ctrl_chk #(
   parameter int            TW        = 8,
   parameter logic [TW-1:0] LO_PRESET = 8'hFF,
   parameter logic [TW-1:0] HI_PRESET = 8'h07
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stop_req,
   input logic          wake_evt,
   input logic          core_rst_n,
   input logic          core_clk_en,
   input logic          cascade_force,
   input logic          stopped,
   input logic          hi_ovf,
   input logic [TW-1:0] lo_cnt,
   input logic [TW-1:0] hi_cnt
);

   p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cascade_force != core_clk_en);

   p_preset_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cascade_force) |-> (lo_cnt == LO_PRESET && hi_cnt == HI_PRESET));

   p_reset_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_n |=> core_rst_n);

   p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && stop_req) |=> (!core_clk_en && core_rst_n));

   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !wake_evt) |=> (stopped && $stable(lo_cnt) && $stable(hi_cnt)));

   p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && !stop_req) |=> core_clk_en);

   p_release_on_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_clk_en) |-> $past(hi_ovf));

endmodule

bind osw_ctrl osw_ctrl_chk #(
   .TW        (TW),
   .LO_PRESET (LO_PRESET),
   .HI_PRESET (HI_PRESET)
) u_chk (
   .clk           (clk),
   .rst_n         (ext_rst_n),
   .stop_req      (stop_req),
   .wake_evt      (wake_evt),
   .core_rst_n    (core_rst_n),
   .core_clk_en   (core_clk_en),
   .cascade_force (cascade_force),
   .stopped       (seq_stopped),
   .hi_ovf        (stage_ovf[1]),
   .lo_cnt        (stage_cnt[0]),
   .hi_cnt        (stage_cnt[1])
);

// File: tb/osw_ctrl_tb.sv
`timescale 1ns/1ps
module osw_ctrl_tb;

   localparam int TICKS = 256 * 8;

   logic       clk = 1'b0;
   logic       ext_rst_n = 1'b0;
   logic       stop_req = 1'b0;
   logic       wake_evt = 1'b0;
   logic [1:0] lo_src_sel = 2'b00;
   logic       core_rst_n;
   logic       core_clk_en;
   logic       cascade_force;
   logic [7:0] lo_preset;
   logic [7:0] hi_preset;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   osw_ctrl u_dut (
      .clk           (clk),
      .ext_rst_n     (ext_rst_n),
      .stop_req      (stop_req),
      .wake_evt      (wake_evt),
      .lo_src_sel    (lo_src_sel),
      .core_rst_n    (core_rst_n),
      .core_clk_en   (core_clk_en),
      .cascade_force (cascade_force),
      .lo_preset     (lo_preset),
      .hi_preset     (hi_preset)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // Reset, then release; sel forced to a non-/16 value to show it is ignored (R2).
   // A stop and a wake pulse land mid-wait (R7, R8).
   task automatic t_reset_wait(input logic [1:0] sel);
      @(negedge clk);
      ext_rst_n  = 1'b0;
      lo_src_sel = sel;
      stop_req   = 1'b1;
      wake_evt   = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "core_rst_n in reset", core_rst_n, 0);
      chk("R1", "core_clk_en in reset", core_clk_en, 0);
      chk("R1", "cascade_force in reset", cascade_force, 1);
      chk("R1", "lo_preset in reset", lo_preset, 8'hFF);
      chk("R1", "hi_preset in reset", hi_preset, 8'h07);
      stop_req  = 1'b0;
      wake_evt  = 1'b0;
      ext_rst_n = 1'b1;
      for (int i = 1; i < 16 * TICKS; i++) begin
         stop_req = (i == 5000);
         wake_evt = (i == 9000);
         @(negedge clk);
      end
      stop_req = 1'b0;
      wake_evt = 1'b0;
      chk("R2", "core_rst_n one edge before release", core_rst_n, 0);
      chk("R7", "core_clk_en one edge before release", core_clk_en, 0);
      @(negedge clk);
      chk("R2", "core_rst_n at release edge", core_rst_n, 1);
      chk("R2", "core_clk_en at release edge", core_clk_en, 1);
      chk("R3", "cascade_force after release", cascade_force, 0);
      chk("R3", "lo_preset after release", lo_preset, 0);
   endtask

   // Stop, hold, wake, timed release. div = expected divider for sel.
   task automatic t_stop_wait(input logic [1:0] sel, input int div, input bit disturb);
      @(negedge clk);
      lo_src_sel = sel;
      stop_req   = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      chk("R4", "core_clk_en after stop", core_clk_en, 0);
      chk("R4", "core_rst_n after stop", core_rst_n, 1);
      chk("R3", "hi_preset while stopped", hi_preset, 8'h07);
      if (disturb) lo_src_sel = ~sel;
      repeat (300) @(negedge clk);
      chk("R5", "core_clk_en stopped without wake", core_clk_en, 0);
      wake_evt = 1'b1;
      @(negedge clk);
      wake_evt = 1'b0;
      for (int i = 1; i < div * TICKS; i++) begin
         stop_req = disturb && (i == div * TICKS / 2);
         if (disturb && (i % 7 == 0)) lo_src_sel = lo_src_sel + 2'd1;
         @(negedge clk);
      end
      stop_req = 1'b0;
      chk(disturb ? "R9" : "R6", "core_clk_en one edge before release", core_clk_en, 0);
      @(negedge clk);
      chk(disturb ? "R7" : "R6", "core_clk_en at release edge", core_clk_en, 1);
      chk("R6", "cascade_force at release edge", cascade_force, 0);
   endtask

   task automatic t_wake_in_run();
      @(negedge clk);
      wake_evt = 1'b1;
      repeat (4) @(negedge clk);
      wake_evt = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8", "core_clk_en after wake while running", core_clk_en, 1);
      chk("R8", "cascade_force after wake while running", cascade_force, 0);
   endtask

   initial begin
      t_reset_wait(2'b11);
      t_wake_in_run();
      t_stop_wait(2'b00, 16, 1'b1);
      t_stop_wait(2'b01, 2, 1'b0);
      t_stop_wait(2'b10, 1, 1'b1);
      t_stop_wait(2'b11, 1, 1'b0);
      t_reset_wait(2'b00);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule